// File: doc/BRIEF.md
# Crosspoint switch control memory

This block holds the on/off state of every crosspoint in a matrix of 8 columns by 16 rows. One storage bit per crosspoint is built as a resettable, level-sensitive transparent latch. A write selects one crosspoint with a 3-bit column address and a 4-bit row address. The latch for that crosspoint opens while both chip select and the strobe are high. It then passes the data input straight to its output and closes on the falling edge of the strobe. The stored bits cannot be read back. The only output is the full connection matrix, which drives the switch fabric.

The row address is logical: the block maps it to a physical row through a fixed permutation before it decodes. The column address is used as given. An active-high master reset clears every crosspoint at once, without any strobe and whatever the chip select does. Chip select lets several of these arrays share one address, data and strobe bus when the matrix is built larger.

Top module: `xpt_ctrl_mem`

## Requirements
- R1: While `reset_i` is high, every bit of `xpoint_o` is 0, with no strobe needed and whatever the level of `cs_i`; after reset the output stays all zeros until a write takes place.
- R2: While `cs_i` and `strobe_i` are both high, the addressed crosspoint bit follows every change of `data_i`.
- R3: The level of `data_i` just before `strobe_i` falls is the value held afterwards. 1 closes the crosspoint and 0 opens it. Later changes of `data_i` leave the held value unchanged.
- R4: A write changes only the addressed crosspoint bit; all 127 others keep their values.
- R5: Raising `reset_i` during a write in progress (`cs_i` and `strobe_i` high) clears the addressed bit as well as all others. The bit stays 0 when the strobe then falls under reset.
- R6: With `cs_i` low, a pulse on `strobe_i` changes no crosspoint, whatever the address and data.
- R7: Row address values 0..5 select physical rows 0..5, values 6..7 select rows 12..13, values 8..13 select rows 6..11, and values 14..15 select rows 14..15.
- R8: The column address selects column 0..7 directly. The crosspoint at column c and physical row p is bit `c*16 + p` of `xpoint_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reset_i | input | 1 | Master clear, active high, asynchronous to everything |
| cs_i | input | 1 | Chip select, active high; gates the strobe |
| strobe_i | input | 1 | Write strobe, active high; the value is captured on its falling edge |
| data_i | input | 1 | Value for the addressed crosspoint, 1 = closed |
| col_addr_i | input | 3 | Column address |
| row_addr_i | input | 4 | Logical row address, permuted before decoding |
| xpoint_o | output | 128 | Connection matrix, bit `col*16 + physical_row` |

## Verification
The assertions watch every falling edge of the strobe. Each one checks that the crosspoint chosen by the checker's own address map equals the data then present. Each falling edge of reset is checked to come after an all-zero matrix. Whenever chip select is low, the checker also requires no latch enable to be active, and it never allows more than one enable at a time. The bench's scenarios are needed for the rest: a write that disturbs no other bit, a value held after the strobe falls while the data keeps moving, reset cutting into a write in progress, and the full row permutation, which an exhaustive sweep of all 128 addresses covers one address at a time.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  localparam int unsigned XPT_COLS = 8;
  localparam int unsigned XPT_ROWS = 16;

  // Logical-to-physical row permutation of the 16-row fabric.
  // The middle band is swapped: 6..7 go up to 12..13, 8..13 go down to 6..11.
  function automatic int unsigned phys_row(input int unsigned logical);
    int unsigned p;
    p = logical;
    if (logical >= 6 && logical <= 7)
      p = logical + 6;
    else if (logical >= 8 && logical <= 13)
      p = logical - 2;
    return p;
  endfunction

endpackage

// File: rtl/xpt_addr_decode.sv
module xpt_addr_decode #(
  parameter int unsigned NUM_COLS    = xpt_pkg::XPT_COLS,
  parameter int unsigned NUM_ROWS    = xpt_pkg::XPT_ROWS,
  parameter bit          ROW_SWIZZLE = 1'b1,
  localparam int unsigned COL_AW     = $clog2(NUM_COLS),
  localparam int unsigned ROW_AW     = $clog2(NUM_ROWS),
  localparam int unsigned CELLS      = NUM_COLS * NUM_ROWS
) (
  input  logic [COL_AW-1:0] col_addr_i,
  input  logic [ROW_AW-1:0] row_addr_i,
  input  logic              wr_gate_i,
  output logic [CELLS-1:0]  en_o
);

  logic [NUM_COLS-1:0] col_hit;
  logic [NUM_ROWS-1:0] row_hit;

  // One-hot column and logical row selects, each qualified once.
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_hit[c] = wr_gate_i && (col_addr_i == COL_AW'(c));
  end

  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
    assign row_hit[r] = (row_addr_i == ROW_AW'(r));
  end

  // Route each logical row to its physical slot in the enable vector.
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_cell_c
    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_cell_r
      localparam int unsigned PHYS = ROW_SWIZZLE ? xpt_pkg::phys_row(r) : r;
      assign en_o[c*NUM_ROWS + PHYS] = col_hit[c] && row_hit[r];
    end
  end

endmodule

// File: rtl/xpt_cell_latch.sv
module xpt_cell_latch (
  input  logic clr_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);

  // Resettable transparent latch: clear dominates, open while enabled.
  always_latch begin
    if (clr_i)
      q_o <= 1'b0;
    else if (en_i)
      q_o <= d_i;
  end

endmodule

// File: rtl/xpt_ctrl_mem.sv
module xpt_ctrl_mem #(
  parameter int unsigned NUM_COLS    = xpt_pkg::XPT_COLS,
  parameter int unsigned NUM_ROWS    = xpt_pkg::XPT_ROWS,
  parameter bit          ROW_SWIZZLE = 1'b1,
  localparam int unsigned COL_AW     = $clog2(NUM_COLS),
  localparam int unsigned ROW_AW     = $clog2(NUM_ROWS),
  localparam int unsigned CELLS      = NUM_COLS * NUM_ROWS
) (
  input  logic              reset_i,
  input  logic              cs_i,
  input  logic              strobe_i,
  input  logic              data_i,
  input  logic [COL_AW-1:0] col_addr_i,
  input  logic [ROW_AW-1:0] row_addr_i,
  output logic [CELLS-1:0]  xpoint_o
);

  logic             wr_gate;
  logic [CELLS-1:0] cell_en;

  assign wr_gate = cs_i && strobe_i;

  xpt_addr_decode #(
    .NUM_COLS    (NUM_COLS),
    .NUM_ROWS    (NUM_ROWS),
    .ROW_SWIZZLE (ROW_SWIZZLE)
  ) u_decode (
    .col_addr_i (col_addr_i),
    .row_addr_i (row_addr_i),
    .wr_gate_i  (wr_gate),
    .en_o       (cell_en)
  );

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    xpt_cell_latch u_cell (
      .clr_i (reset_i),
      .en_i  (cell_en[i]),
      .d_i   (data_i),
      .q_o   (xpoint_o[i])
    );
  end

endmodule

// File: rtl/xpt_ctrl_mem_chk.sv
module xpt_ctrl_mem_chk #(
  parameter int unsigned NUM_COLS    = xpt_pkg::XPT_COLS,
  parameter int unsigned NUM_ROWS    = xpt_pkg::XPT_ROWS,
  parameter bit          ROW_SWIZZLE = 1'b1,
  localparam int unsigned COL_AW     = $clog2(NUM_COLS),
  localparam int unsigned ROW_AW     = $clog2(NUM_ROWS),
  localparam int unsigned CELLS      = NUM_COLS * NUM_ROWS
) (
  input logic              reset_i,
  input logic              cs_i,
  input logic              strobe_i,
  input logic              data_i,
  input logic [COL_AW-1:0] col_addr_i,
  input logic [ROW_AW-1:0] row_addr_i,
  input logic [CELLS-1:0]  xpoint_o,
  input logic [CELLS-1:0]  en_i
);

  // Independent statement of the row map, written as ranges.
  function automatic int unsigned cell_of(input logic [COL_AW-1:0] c,
                                          input logic [ROW_AW-1:0] r);
    int unsigned l;
    int unsigned p;
    l = int'(r);
    if (!ROW_SWIZZLE || l < 6 || l > 13) p = l;
    else if (l < 8)                      p = l + 6;
    else                                 p = l - 2;
    return int'(c) * NUM_ROWS + p;
  endfunction

  // R2 R3 R7 R8: at the closing edge the mapped cell carries the data.
  p_capture_r2: assert property (@(negedge strobe_i) disable iff (reset_i)
    cs_i |-> (xpoint_o[cell_of(col_addr_i, row_addr_i)] == data_i))
    else $error("p_capture_r2 violated");

  // R1 R5: reset leaves an empty matrix behind it.
  p_clear_r1: assert property (@(negedge reset_i) disable iff (reset_i)
    1'b1 |-> (xpoint_o == '0))
    else $error("p_clear_r1 violated");

  // R6: no latch may open while chip select is low.
  // R4: at most one latch open at any time.
  always_comb begin
    if (!cs_i) begin
      p_cs_gate_r6: assert (en_i == '0) else $error("p_cs_gate_r6 violated");
    end
    p_single_cell_r4: assert ($onehot0(en_i)) else $error("p_single_cell_r4 violated");
  end

endmodule

bind xpt_ctrl_mem xpt_ctrl_mem_chk #(
  .NUM_COLS    (NUM_COLS),
  .NUM_ROWS    (NUM_ROWS),
  .ROW_SWIZZLE (ROW_SWIZZLE)
) u_chk (
  .reset_i    (reset_i),
  .cs_i       (cs_i),
  .strobe_i   (strobe_i),
  .data_i     (data_i),
  .col_addr_i (col_addr_i),
  .row_addr_i (row_addr_i),
  .xpoint_o   (xpoint_o),
  .en_i       (cell_en)
);

// File: tb/xpt_ctrl_mem_test.sv
module xpt_ctrl_mem_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;
  localparam int NR = 16;
  localparam int NCELL = NC * NR;

  logic             clk = 1'b0;
  logic             reset_i = 1'b1;
  logic             cs_i = 1'b0;
  logic             strobe_i = 1'b0;
  logic             data_i = 1'b0;
  logic [2:0]       col_addr_i = '0;
  logic [3:0]       row_addr_i = '0;
  logic [NCELL-1:0] xpoint_o;

  logic [NCELL-1:0] ref_v = '0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpt_ctrl_mem uut (
    .reset_i    (reset_i),
    .cs_i       (cs_i),
    .strobe_i   (strobe_i),
    .data_i     (data_i),
    .col_addr_i (col_addr_i),
    .row_addr_i (row_addr_i),
    .xpoint_o   (xpoint_o)
  );

  // Expected bit position, R7 and R8 rules computed arithmetically.
  function automatic int exp_idx(input int c, input int r);
    int p;
    p = (r >= 6 && r <= 7) ? r + 6 : ((r >= 8 && r <= 13) ? r - 2 : r);
    return c * NR + p;
  endfunction

  task automatic check(input string req, input logic [NCELL-1:0] exp);
    @(negedge clk);
    total++;
    if (xpoint_o !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, xpoint_o, exp);
    end
  endtask

  task automatic wr(input int c, input int r, input bit d);
    @(posedge clk);
    col_addr_i = 3'(c); row_addr_i = 4'(r); data_i = d; cs_i = 1'b1;
    @(posedge clk); strobe_i = 1'b1;
    @(posedge clk); strobe_i = 1'b0;
    @(posedge clk); cs_i = 1'b0;
    ref_v[exp_idx(c, r)] = d;
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    // R1: reset state, with chip select low and high
    repeat (2) @(posedge clk);
    check("R1 under reset", '0);
    @(posedge clk); cs_i = 1'b1;
    check("R1 under reset cs high", '0);
    @(posedge clk); cs_i = 1'b0; reset_i = 1'b0;
    check("R1 after reset", '0);

    // R7 R8: every address lights exactly its mapped bit, then R3 opens it
    for (int c = 0; c < NC; c++) begin
      for (int r = 0; r < NR; r++) begin
        logic [NCELL-1:0] one;
        one = '0;
        one[exp_idx(c, r)] = 1'b1;
        wr(c, r, 1'b1);
        check($sformatf("R7 R8 col=%0d row=%0d", c, r), one);
        wr(c, r, 1'b0);
        check($sformatf("R3 open col=%0d row=%0d", c, r), '0);
      end
    end

    // R4: build a pattern, each write leaving the rest intact
    for (int c = 0; c < NC; c++) begin
      for (int r = 0; r < NR; r++) begin
        if ((c + r) % 3 == 0) begin
          wr(c, r, 1'b1);
          check($sformatf("R4 build col=%0d row=%0d", c, r), ref_v);
        end
      end
    end
    // R4: overwrites that flip one bit each
    for (int r = 0; r < NR; r++) begin
      wr(r % NC, r, ~ref_v[exp_idx(r % NC, r)]);
      check($sformatf("R4 overwrite row=%0d", r), ref_v);
    end

    // R2: bit follows data while the latch is open
    @(posedge clk);
    col_addr_i = 3'd5; row_addr_i = 4'd9; data_i = 1'b0; cs_i = 1'b1;
    @(posedge clk); strobe_i = 1'b1;
    ref_v[exp_idx(5, 9)] = 1'b0;
    check("R2 open data 0", ref_v);
    @(posedge clk); data_i = 1'b1;
    ref_v[exp_idx(5, 9)] = 1'b1;
    check("R2 open data 1", ref_v);
    @(posedge clk); data_i = 1'b0;
    ref_v[exp_idx(5, 9)] = 1'b0;
    check("R2 open data back to 0", ref_v);
    @(posedge clk); data_i = 1'b1;
    @(posedge clk); strobe_i = 1'b0;
    ref_v[exp_idx(5, 9)] = 1'b1;
    check("R3 held after strobe fall", ref_v);
    @(posedge clk); data_i = 1'b0;
    check("R3 data change after close", ref_v);
    @(posedge clk); cs_i = 1'b0;

    // R6: strobe with chip select low touches nothing
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      col_addr_i = 3'(k * 2); row_addr_i = 4'(k * 5);
      data_i = ~ref_v[exp_idx(k * 2, k * 5)];
      @(posedge clk); strobe_i = 1'b1;
      check($sformatf("R6 strobe high cs low k=%0d", k), ref_v);
      @(posedge clk); strobe_i = 1'b0;
      check($sformatf("R6 after pulse k=%0d", k), ref_v);
    end

    // R5: reset cuts into a write in progress
    @(posedge clk);
    col_addr_i = 3'd1; row_addr_i = 4'd7; data_i = 1'b1; cs_i = 1'b1;
    @(posedge clk); strobe_i = 1'b1;
    ref_v[exp_idx(1, 7)] = 1'b1;
    check("R5 write open before reset", ref_v);
    @(posedge clk); reset_i = 1'b1;
    ref_v = '0;
    check("R5 reset during write", '0);
    @(posedge clk); strobe_i = 1'b0;
    check("R5 strobe falls under reset", '0);
    @(posedge clk); reset_i = 1'b0; cs_i = 1'b0;
    check("R5 after reset released", '0);

    // R1: reset with chip select low clears a non-empty matrix
    wr(7, 15, 1'b1);
    wr(0, 0, 1'b1);
    wr(3, 6, 1'b1);
    check("R4 refill", ref_v);
    @(posedge clk); reset_i = 1'b1;
    check("R1 clear with cs low", '0);
    @(posedge clk); reset_i = 1'b0;
    ref_v = '0;
    check("R1 stays clear", '0);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule